// File: doc/BRIEF.md
# Double-Trigger A/D Result Steering Controller

This block sits between the trigger sources of a chip, a single-channel A/D conversion engine and a bank of result registers. It decides when a scan starts and which analog channels are converted, in which order. It also chooses which register receives each conversion result and when the scan-end interrupt fires. In normal mode a trigger scans every channel enabled in a channel bitmap, in ascending order. Each result is written to that channel's data register.

In double-trigger mode the bitmap is ignored and a 5-bit selector names one channel. Scans started by the synchronous hardware trigger alternate between two destinations. The first result goes to the channel's own data register and the second goes to a separate duplication register, which this block holds. The interrupt is held back until the second result has been written. A software-started scan in this mode writes the channel's data register, interrupts at once and leaves the alternation where it was. The asynchronous trigger is not allowed in this mode. If it arrives, a sticky error flag is set and no scan starts.

The configuration is loaded through a write strobe, and it can only be loaded while no scan is running. Triggers that arrive during a scan are dropped, not queued.

Top module: `adc_dup_steer`

## Requirements
- R1: After reset, conv_req, res_we, dup_we, irq, err_async and busy are 0 and dup_data is zero.
- R2: In normal mode an accepted trigger converts each channel whose bit is set in the bitmap, lowest index first, with one conv_req pulse per channel. Each result is written with a one-hot res_we, where bit n means channel n, and the data appears on res_data.
- R3: In normal mode, irq is a one-cycle pulse coincident with the last result write of a scan when irq_en is 1. When irq_en is 0 there is no pulse.
- R4: In double-trigger mode the bitmap has no effect and only the channel given by the selector is converted (selector value n selects channel n for n = 0 to 7). When the selector is NUM_CH or above, every trigger is ignored.
- R5: In double-trigger mode, successive synchronous-trigger scans alternate between destinations. The first writes res_we for the selected channel. The second asserts dup_we and loads its result into dup_data.
- R6: In double-trigger mode with irq_en 1, a synchronous-trigger scan that writes the channel register raises no irq. The one that writes the duplication register raises irq.
- R7: In double-trigger mode a software-triggered scan writes the selected channel's register, raises irq if irq_en is 1, and does not change which destination the next synchronous scan uses.
- R8: With trig_en 0, the synchronous and asynchronous triggers start nothing. With trig_en 1, trig_async 0 selects the synchronous trigger and trig_async 1 the asynchronous one. The software trigger is not gated by trig_en.
- R9: A configuration write is ignored while busy is 1. A trigger arriving while busy is 1, or in the same cycle as an accepted configuration write, is dropped and never replayed.
- R10: An accepted configuration write that changes the double-trigger bit returns the alternation to "first", so the next synchronous scan writes the channel register.
- R11: An asynchronous trigger while double-trigger mode is active sets err_async, which stays 1 until reset, and starts no scan. In normal mode it does not set err_async.
- R12: When a hardware trigger and a software trigger are accepted in the same idle cycle, the scan counts as hardware-started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dbl_en | input | 1 | Double-trigger mode enable |
| cfg_dbl_sel | input | 5 | Double-trigger channel selector |
| cfg_trig_en | input | 1 | Hardware trigger enable |
| cfg_trig_async | input | 1 | 0: synchronous trigger, 1: asynchronous trigger |
| cfg_irq_en | input | 1 | Scan-end interrupt enable |
| cfg_ch_map | input | NUM_CH | Normal-mode channel bitmap |
| sync_trig | input | 1 | Synchronous hardware trigger |
| async_trig | input | 1 | Asynchronous hardware trigger (already synchronised) |
| sw_trig | input | 1 | Software start |
| conv_done | input | 1 | Conversion-complete strobe from the engine |
| conv_data | input | DATA_W | Conversion result |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | CH_W | Channel to convert |
| busy | output | 1 | Scan in progress |
| res_we | output | NUM_CH | One-hot data register write enable |
| res_data | output | DATA_W | Data for res_we |
| dup_we | output | 1 | Duplication register write pulse |
| dup_data | output | DATA_W | Duplication register contents |
| irq | output | 1 | Scan-end interrupt pulse |
| err_async | output | 1 | Sticky misuse flag |

## Verification
Two collisions are forced on purpose. In the first, the synchronous and software triggers are raised in the same idle cycle during double-trigger mode. A software win would show up as an immediate irq on a channel write, so the scoreboard expects a silent channel write followed by a duplication write with irq on the next hardware scan. In the second, a configuration write and a new trigger are presented while a scan is still converting. The scoreboard expects exactly one result from that scan, and a later scan that proves the selector, mode and alternation survived unchanged.

// File: rtl/adc_dup_pkg.sv
package adc_dup_pkg;

  localparam int SEL_W = 5;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SW    = 2'd1,
    SRC_SYNC  = 2'd2,
    SRC_ASYNC = 2'd3
  } start_src_e;

  typedef struct packed {
    logic             dbl_en;
    logic [SEL_W-1:0] dbl_sel;
    logic             trig_en;
    logic             trig_async;
    logic             irq_en;
  } steer_cfg_t;

endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int N    = 8,
  parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    mask,
  output logic [ID_W-1:0] idx,
  output logic            any
);

  // lowest set bit wins: scan downward so the last hit is the lowest index
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = ID_W'(i);
    end
  end

  assign any = |mask;

endmodule

// File: rtl/adc_trig_qual.sv
module adc_trig_qual
  import adc_dup_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  steer_cfg_t        cfg_in,
  input  logic [NUM_CH-1:0] map_in,
  input  logic              sync_trig,
  input  logic              async_trig,
  input  logic              sw_trig,
  input  logic              busy,
  output steer_cfg_t        cfg_q,
  output logic              start,
  output start_src_e        start_src,
  output logic [NUM_CH-1:0] start_mask,
  output logic              phase_clr,
  output logic              err_async
);

  logic [NUM_CH-1:0] map_q;
  logic [NUM_CH-1:0] sel_hot;
  logic              cfg_take;
  logic              hw_fire;

  assign cfg_take  = cfg_we && !busy;
  assign phase_clr = cfg_take && (cfg_in.dbl_en != cfg_q.dbl_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      map_q     <= '0;
      err_async <= 1'b0;
    end else begin
      if (cfg_take) begin
        cfg_q <= cfg_in;
        map_q <= map_in;
      end
      if (async_trig && cfg_q.dbl_en) err_async <= 1'b1;
    end
  end

  // selector decode; values at or above NUM_CH give an empty mask
  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign sel_hot[g] = (cfg_q.dbl_sel == SEL_W'(g));
  end

  assign start_mask = cfg_q.dbl_en ? sel_hot : map_q;

  assign hw_fire = cfg_q.trig_en &&
                   (cfg_q.trig_async ? (async_trig && !cfg_q.dbl_en) : sync_trig);

  assign start = !busy && !cfg_take && (|start_mask) && (hw_fire || sw_trig);

  always_comb begin
    if (hw_fire) start_src = cfg_q.trig_async ? SRC_ASYNC : SRC_SYNC;
    else         start_src = SRC_SW;
  end

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg_q));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_async |=> err_async);

  // R9
  no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_dup_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  start_src_e        start_src,
  input  logic [NUM_CH-1:0] start_mask,
  input  logic              conv_done,
  output logic              busy,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  output logic              evt_valid,
  output logic [CH_W-1:0]   evt_ch,
  output logic              evt_last,
  output start_src_e        evt_src
);

  logic [NUM_CH-1:0] rem_q;
  logic [NUM_CH-1:0] rem_next;
  logic [NUM_CH-1:0] cur_hot;
  logic [CH_W-1:0]   cur_q;
  logic [CH_W-1:0]   first_idx;
  logic [CH_W-1:0]   next_idx;
  logic              first_any;
  logic              next_any;
  logic              busy_q;
  logic              req_q;
  start_src_e        src_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cur
    assign cur_hot[g] = (cur_q == CH_W'(g));
  end

  assign rem_next = rem_q & ~cur_hot;

  adc_chan_pick #(.N(NUM_CH), .ID_W(CH_W)) u_first (
    .mask (start_mask),
    .idx  (first_idx),
    .any  (first_any)
  );

  adc_chan_pick #(.N(NUM_CH), .ID_W(CH_W)) u_next (
    .mask (rem_next),
    .idx  (next_idx),
    .any  (next_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      rem_q  <= '0;
      cur_q  <= '0;
      src_q  <= SRC_NONE;
    end else begin
      req_q <= 1'b0;
      if (!busy_q) begin
        if (start && first_any) begin
          busy_q <= 1'b1;
          rem_q  <= start_mask;
          cur_q  <= first_idx;
          src_q  <= start_src;
          req_q  <= 1'b1;
        end
      end else if (conv_done) begin
        rem_q <= rem_next;
        if (next_any) begin
          cur_q <= next_idx;
          req_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
          src_q  <= SRC_NONE;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign conv_req  = req_q;
  assign conv_ch   = cur_q;
  assign evt_valid = busy_q && conv_done;
  assign evt_ch    = cur_q;
  assign evt_last  = !next_any;
  assign evt_src   = src_q;

  // R2
  req_in_scan_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |-> busy_q);

  // R2
  req_chan_pending_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |-> rem_q[cur_q]);

endmodule

// File: rtl/adc_dup_route.sv
module adc_dup_route
  import adc_dup_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbl_en,
  input  logic              irq_en,
  input  logic              phase_clr,
  input  logic              evt_valid,
  input  logic [CH_W-1:0]   evt_ch,
  input  logic              evt_last,
  input  start_src_e        evt_src,
  input  logic [DATA_W-1:0] evt_data,
  output logic [NUM_CH-1:0] res_we,
  output logic [DATA_W-1:0] res_data,
  output logic              dup_we,
  output logic [DATA_W-1:0] dup_data,
  output logic              irq
);

  logic [NUM_CH-1:0] ch_hot;
  logic              second_q;
  logic              pair_scan;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hot
    assign ch_hot[g] = (evt_ch == CH_W'(g));
  end

  assign pair_scan = dbl_en && (evt_src == SRC_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_we   <= '0;
      res_data <= '0;
      dup_we   <= 1'b0;
      dup_data <= '0;
      irq      <= 1'b0;
      second_q <= 1'b0;
    end else begin
      res_we <= '0;
      dup_we <= 1'b0;
      irq    <= 1'b0;
      if (evt_valid) begin
        res_data <= evt_data;
        if (pair_scan && second_q) begin
          dup_we   <= 1'b1;
          dup_data <= evt_data;
          second_q <= 1'b0;
          irq      <= irq_en && evt_last;
        end else begin
          res_we <= ch_hot;
          if (pair_scan) second_q <= 1'b1;
          else           irq      <= irq_en && evt_last;
        end
      end
      if (phase_clr) second_q <= 1'b0;
    end
  end

  // R2
  we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(res_we));

  // R5
  excl_we_chk: assert property (@(posedge clk) disable iff (rst)
    !(dup_we && (|res_we)));

  // R3
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R6
  first_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && pair_scan && !second_q) |=> !irq);

endmodule

// File: rtl/adc_dup_steer.sv
module adc_dup_steer
  import adc_dup_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_dbl_en,
  input  logic [SEL_W-1:0]  cfg_dbl_sel,
  input  logic              cfg_trig_en,
  input  logic              cfg_trig_async,
  input  logic              cfg_irq_en,
  input  logic [NUM_CH-1:0] cfg_ch_map,
  input  logic              sync_trig,
  input  logic              async_trig,
  input  logic              sw_trig,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  output logic              busy,
  output logic [NUM_CH-1:0] res_we,
  output logic [DATA_W-1:0] res_data,
  output logic              dup_we,
  output logic [DATA_W-1:0] dup_data,
  output logic              irq,
  output logic              err_async
);

  steer_cfg_t        cfg_wr;
  steer_cfg_t        cfg_q;
  logic              start;
  start_src_e        start_src;
  logic [NUM_CH-1:0] start_mask;
  logic              phase_clr;
  logic              evt_valid;
  logic [CH_W-1:0]   evt_ch;
  logic              evt_last;
  start_src_e        evt_src;

  assign cfg_wr.dbl_en     = cfg_dbl_en;
  assign cfg_wr.dbl_sel    = cfg_dbl_sel;
  assign cfg_wr.trig_en    = cfg_trig_en;
  assign cfg_wr.trig_async = cfg_trig_async;
  assign cfg_wr.irq_en     = cfg_irq_en;

  adc_trig_qual #(.NUM_CH(NUM_CH)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_in     (cfg_wr),
    .map_in     (cfg_ch_map),
    .sync_trig  (sync_trig),
    .async_trig (async_trig),
    .sw_trig    (sw_trig),
    .busy       (busy),
    .cfg_q      (cfg_q),
    .start      (start),
    .start_src  (start_src),
    .start_mask (start_mask),
    .phase_clr  (phase_clr),
    .err_async  (err_async)
  );

  adc_scan_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_src  (start_src),
    .start_mask (start_mask),
    .conv_done  (conv_done),
    .busy       (busy),
    .conv_req   (conv_req),
    .conv_ch    (conv_ch),
    .evt_valid  (evt_valid),
    .evt_ch     (evt_ch),
    .evt_last   (evt_last),
    .evt_src    (evt_src)
  );

  adc_dup_route #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_route (
    .clk       (clk),
    .rst       (rst),
    .dbl_en    (cfg_q.dbl_en),
    .irq_en    (cfg_q.irq_en),
    .phase_clr (phase_clr),
    .evt_valid (evt_valid),
    .evt_ch    (evt_ch),
    .evt_last  (evt_last),
    .evt_src   (evt_src),
    .evt_data  (conv_data),
    .res_we    (res_we),
    .res_data  (res_data),
    .dup_we    (dup_we),
    .dup_data  (dup_data),
    .irq       (irq)
  );

  // R4
  dbl_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_req && cfg_q.dbl_en) |-> (SEL_W'(conv_ch) == cfg_q.dbl_sel));

endmodule

// File: tb/adc_dup_steer_tb_top.sv
module adc_dup_steer_tb_top;
  import adc_dup_pkg::*;

  localparam int NUM_CH = 8;
  localparam int DATA_W = 12;
  localparam int CH_W   = $clog2(NUM_CH);

  typedef struct {
    bit    dup;
    int    ch;
    bit    irq;
    string req;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic              cfg_dbl_en = 1'b0;
  logic [SEL_W-1:0]  cfg_dbl_sel = '0;
  logic              cfg_trig_en = 1'b0;
  logic              cfg_trig_async = 1'b0;
  logic              cfg_irq_en = 1'b0;
  logic [NUM_CH-1:0] cfg_ch_map = '0;
  logic              sync_trig = 1'b0;
  logic              async_trig = 1'b0;
  logic              sw_trig = 1'b0;
  logic              conv_done = 1'b0;
  logic [DATA_W-1:0] conv_data = '0;
  logic              conv_req;
  logic [CH_W-1:0]   conv_ch;
  logic              busy;
  logic [NUM_CH-1:0] res_we;
  logic [DATA_W-1:0] res_data;
  logic              dup_we;
  logic [DATA_W-1:0] dup_data;
  logic              irq;
  logic              err_async;

  int checks = 0;
  int fails  = 0;
  exp_t              exp_q[$];
  logic [DATA_W-1:0] eng_q[$];

  always #5 clk = ~clk;

  adc_dup_steer #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dbl_en(cfg_dbl_en),
    .cfg_dbl_sel(cfg_dbl_sel), .cfg_trig_en(cfg_trig_en),
    .cfg_trig_async(cfg_trig_async), .cfg_irq_en(cfg_irq_en),
    .cfg_ch_map(cfg_ch_map), .sync_trig(sync_trig), .async_trig(async_trig),
    .sw_trig(sw_trig), .conv_done(conv_done), .conv_data(conv_data),
    .conv_req(conv_req), .conv_ch(conv_ch), .busy(busy), .res_we(res_we),
    .res_data(res_data), .dup_we(dup_we), .dup_data(dup_data), .irq(irq),
    .err_async(err_async)
  );

  // conversion engine model: result two cycles after a request
  int eng_cnt = 0;
  int eng_seq = 0;
  int eng_ch  = 0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        conv_data = DATA_W'((eng_ch << 8) | (eng_seq & 8'hFF));
        eng_seq++;
        conv_done = 1'b1;
        eng_q.push_back(conv_data);
      end
    end
    if (!rst && conv_req) begin
      eng_cnt = 2;
      eng_ch  = int'(conv_ch);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && ((|res_we) || dup_we || irq)) begin
      exp_t e;
      logic [DATA_W-1:0] d;
      logic [DATA_W-1:0] got;
      d = '0;
      if (eng_q.size() != 0) d = eng_q.pop_front();
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected write: res_we=%b dup_we=%0b irq=%0b expected none",
                 res_we, dup_we, irq);
      end else begin
        e = exp_q.pop_front();
        got = dup_we ? dup_data : res_data;
        if (dup_we != e.dup || irq != e.irq || got != d ||
            $countones(res_we) != (e.dup ? 0 : 1) ||
            (!e.dup && !res_we[e.ch])) begin
          fails++;
          $display("FAIL %s: res_we=%b dup_we=%0b irq=%0b data=%h expected ch=%0d dup=%0b irq=%0b data=%h",
                   e.req, res_we, dup_we, irq, got, e.ch, e.dup, e.irq, d);
        end
      end
    end
  end

  task automatic expect_wr(input bit dup, input int ch, input bit irq_x, input string req);
    exp_t e;
    e.dup = dup; e.ch = ch; e.irq = irq_x; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic write_cfg(input bit dbl, input int sel, input bit ten,
                           input bit tasync, input bit ien, input logic [NUM_CH-1:0] map);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dbl_en = dbl; cfg_dbl_sel = SEL_W'(sel);
    cfg_trig_en = ten; cfg_trig_async = tasync; cfg_irq_en = ien; cfg_ch_map = map;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // which: 0 sync, 1 async, 2 software, 3 sync+software
  task automatic fire(input int which);
    @(negedge clk);
    sync_trig  = (which == 0 || which == 3);
    async_trig = (which == 1);
    sw_trig    = (which == 2 || which == 3);
    @(negedge clk);
    sync_trig = 1'b0; async_trig = 1'b0; sw_trig = 1'b0;
  endtask

  task automatic settle(input string req);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d writes missing, expected 0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic check_bit(input logic act, input logic exp_v, input string req);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp_v);
    end
  endtask

  task automatic run_all();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (conv_req !== 1'b0 || res_we !== '0 || dup_we !== 1'b0 || irq !== 1'b0 ||
        err_async !== 1'b0 || busy !== 1'b0 || dup_data !== '0) begin
      fails++;
      $display("FAIL R1: req=%b we=%b dup=%b irq=%b err=%b busy=%b dd=%h expected all zero",
               conv_req, res_we, dup_we, irq, err_async, busy, dup_data);
    end

    // R2 R3 normal scan ascending, irq on last
    write_cfg(0, 0, 1, 0, 1, 8'b1010_0101);
    expect_wr(0, 0, 0, "R2"); expect_wr(0, 2, 0, "R2");
    expect_wr(0, 5, 0, "R2"); expect_wr(0, 7, 1, "R3");
    fire(0); settle("R2");

    // R3 irq disabled, software start
    write_cfg(0, 0, 1, 0, 0, 8'b0000_0010);
    expect_wr(0, 1, 0, "R3");
    fire(2); settle("R3");

    // R8 hardware triggers gated
    write_cfg(0, 0, 0, 0, 1, 8'b0000_1000);
    fire(0); fire(1); settle("R8");
    check_bit(busy, 1'b0, "R8 gated");
    // R8 async source selected: sync ignored, async starts
    write_cfg(0, 0, 1, 1, 1, 8'b0000_1000);
    fire(0); settle("R8 sync ignored");
    expect_wr(0, 3, 1, "R8");
    fire(1); settle("R8 async");
    check_bit(err_async, 1'b0, "R11 normal mode");

    // R4 R5 R6 double mode, map ignored
    write_cfg(1, 3, 1, 0, 1, 8'hFF);
    expect_wr(0, 3, 0, "R6"); fire(0); settle("R5");
    expect_wr(1, 3, 1, "R5"); fire(0); settle("R6");

    // R7 software keeps phase
    expect_wr(0, 3, 0, "R5"); fire(0); settle("R7");
    expect_wr(0, 3, 1, "R7"); fire(2); settle("R7");
    expect_wr(1, 3, 1, "R7"); fire(0); settle("R7");

    // R10 mode change resets phase
    expect_wr(0, 3, 0, "R10"); fire(0); settle("R10");
    write_cfg(0, 3, 1, 0, 1, 8'h00);
    write_cfg(1, 3, 1, 0, 1, 8'h00);
    expect_wr(0, 3, 0, "R10"); fire(0); settle("R10");
    expect_wr(1, 3, 1, "R10"); fire(0); settle("R10");

    // R11 async in double mode
    fire(1); settle("R11");
    check_bit(err_async, 1'b1, "R11 set");
    write_cfg(1, 3, 1, 1, 1, 8'h00);
    fire(1); settle("R11 no scan");
    write_cfg(1, 3, 1, 0, 1, 8'h00);
    repeat (5) @(negedge clk);
    check_bit(err_async, 1'b1, "R11 sticky");

    // R9 write and trigger during busy are dropped
    expect_wr(0, 3, 0, "R9");
    @(negedge clk); sync_trig = 1'b1;
    @(negedge clk); sync_trig = 1'b0;
    check_bit(busy, 1'b1, "R9 busy");
    cfg_we = 1'b1; cfg_dbl_en = 1'b0; cfg_dbl_sel = 5'd5; sync_trig = 1'b1;
    @(negedge clk); cfg_we = 1'b0; sync_trig = 1'b0;
    settle("R9");
    expect_wr(1, 3, 1, "R9"); fire(0); settle("R9 cfg kept");

    // R12 simultaneous hardware and software triggers
    expect_wr(0, 3, 0, "R12"); fire(3); settle("R12");
    expect_wr(1, 3, 1, "R12"); fire(0); settle("R12");

    // R4 selector edges
    write_cfg(1, 7, 1, 0, 1, 8'h01);
    expect_wr(0, 7, 0, "R4"); fire(0); settle("R4");
    expect_wr(1, 7, 1, "R4"); fire(0); settle("R4");
    write_cfg(1, 0, 1, 0, 1, 8'h80);
    expect_wr(0, 0, 0, "R4"); fire(0); settle("R4");
    expect_wr(1, 0, 1, "R4"); fire(0); settle("R4");
    write_cfg(1, 9, 1, 0, 1, 8'hFF);
    fire(0); fire(2); settle("R4 out of range");
    check_bit(busy, 1'b0, "R4 out of range");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule